// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is one transmit channel of a descriptor-driven DMA engine. Software builds a linked list of four-word descriptors in a shared word-addressed memory and hands the list to the engine by writing the address of the first descriptor into a head register. The engine then visits each descriptor in turn. It reads the link, length and mode words, and sends each descriptor that software still owns out as one packet record on a ready/valid stream. It then hands the descriptor back by rewriting its mode word, and follows the link.

At the end of a list the engine flags the last descriptor so that software can see the queue drained, and can spot an append that arrived too late and restart the queue from a fresh head pointer. A teardown command stops the channel part-way through. The engine marks the abandoned descriptor and confirms the stop with a fixed sentinel in the completion register. A soft reset brings the engine back to its reset state from the register side.

Top module: `txq_desc_engine`

## Requirements
- R12: After reset every readable register returns 0, and `out_valid`, `busy` and `head_err` are 0. The registers are word indexed: 0 control (bit 0 enable), 1 head pointer, 2 completion pointer, 3 teardown command, 4 soft reset. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R1: A descriptor at byte address A occupies memory words A/4 to A/4+3, in this order: link, buffer address, buffer length, mode. Descriptor addresses are 16-byte aligned, and the low four address bits are ignored.
- R2: A write of a nonzero value to the head register starts processing when the enable bit is 1 and the engine is idle. A head write while the enable bit is 0, or a head write of 0, starts nothing: `busy` stays 0 and the head register keeps reading 0.
- R3: Each descriptor whose mode bit 29 (owner) is set produces one stream record. `out_len` carries bits 10:0 of the length word, and `out_len` is held stable while `out_valid` is high and `out_ready` is low.
- R4: `out_directed` is 1 and `out_port` carries mode bits 18:16 only when mode bit 20 is set and that field equals 1 or 2. In every other case both outputs are 0.
- R5: After its record is accepted, the descriptor's mode word is written back with bit 29 cleared and all other bits preserved. This write happens before the next descriptor is read.
- R6: When the link word is 0, the write-back also sets mode bit 28 (end of queue), the engine goes idle and the head register reads 0. A later head write restarts the channel at the new descriptor.
- R7: A fetched descriptor whose owner bit is clear ends the walk. It produces no record and no write, and its successor is not visited. The engine goes idle with the head register reading 0.
- R8: A head write while `busy` is 1 is ignored: the head register keeps the current descriptor address. `head_err` pulses high for exactly one cycle.
- R9: The completion register holds whatever software last wrote to it and reads it back.
- R10: A teardown write whose data equals the channel number `CHAN_ID` drops any pending record. It writes the current owned descriptor's mode back with bit 27 set and bit 29 cleared, leaves later descriptors untouched, idles the engine and loads 0xFFFFFFFC into the completion register. With the engine already idle, only the sentinel is loaded. A teardown write with any other value has no effect.
- R11: Writing 1 in bit 0 of the soft-reset register makes that register read 1 for `SRST_CYCLES` cycles and 0 afterwards. It also clears the enable bit, the completion register and the engine state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| head_err | output | 1 | One-cycle pulse on a head write while busy |
| busy | output | 1 | Engine is walking a list |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| out_valid | output | 1 | Packet record valid |
| out_ready | input | 1 | Packet record accepted |
| out_len | output | 11 | Packet length |
| out_directed | output | 1 | Record targets a specific port |
| out_port | output | 3 | Target port when directed |

## Verification
The bench builds the engine with an 8-bit memory word address, a 3-cycle soft reset and channel number 2. The small memory lets the bench hold several chains side by side. The nonzero channel number lets a teardown write of 0 be shown to do nothing. The short soft reset lets both the busy and the finished readback of the soft-reset register be seen within a few register reads. Backpressure from a low `out_ready` parks the engine on one descriptor, which puts the busy head write and a mid-packet teardown within reach.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 11;
  localparam int PORT_W = 3;

  // mode word bit positions (software decodes these)
  localparam int MB_SOP   = 31;
  localparam int MB_EOP   = 30;
  localparam int MB_OWN   = 29;
  localparam int MB_EOQ   = 28;
  localparam int MB_TDC   = 27;
  localparam int MB_CRC   = 26;
  localparam int MB_DIR   = 20;
  localparam int MB_PORT0 = 16;

  localparam logic [WORD_W-1:0] TD_SENTINEL = 32'hFFFF_FFFC;
  localparam logic [WORD_W-1:0] DESC_MASK   = 32'hFFFF_FFF0;

  // word offsets inside a descriptor
  localparam logic [1:0] OFS_LINK = 2'd0;
  localparam logic [1:0] OFS_LEN  = 2'd2;
  localparam logic [1:0] OFS_MODE = 2'd3;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_HEAD  = 3'd1,
    RA_COMPL = 3'd2,
    RA_TDOWN = 3'd3,
    RA_SRST  = 3'd4
  } reg_addr_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_REQ_LINK,
    W_REQ_LEN,
    W_REQ_MODE,
    W_CHECK,
    W_EMIT,
    W_RETIRE,
    W_ABORT
  } walk_state_e;

endpackage

// File: rtl/txq_route.sv
module txq_route
  import txq_pkg::*;
(
  input  logic [WORD_W-1:0] mode,
  output logic              directed,
  output logic [PORT_W-1:0] port
);
  logic [PORT_W-1:0] field;
  logic              legal;

  always_comb begin
    field    = mode[MB_PORT0 +: PORT_W];
    legal    = mode[MB_DIR] && ((field == PORT_W'(1)) || (field == PORT_W'(2)));
    directed = legal;
    port     = legal ? field : '0;
  end
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int CHAN_ID     = 0,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              head_err,
  input  logic              eng_busy,
  input  logic [WORD_W-1:0] eng_head,
  input  logic              td_done,
  output logic              start,
  output logic [WORD_W-1:0] start_ptr,
  output logic              td_req,
  output logic              eng_rst
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  logic              enable;
  logic [WORD_W-1:0] compl;
  logic [CW-1:0]     srst_cnt;
  logic              srst_active;
  logic              wr_head;

  always_comb begin
    srst_active = (srst_cnt != '0);
    wr_head     = reg_wr && (reg_addr == RA_HEAD);
    start       = wr_head && enable && !eng_busy && (reg_wdata != '0) && !srst_active;
    start_ptr   = reg_wdata;
    td_req      = reg_wr && (reg_addr == RA_TDOWN) && (reg_wdata == WORD_W'(CHAN_ID))
                  && !srst_active;
    eng_rst     = rst || srst_active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      compl     <= '0;
      srst_cnt  <= '0;
      head_err  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      head_err <= wr_head && eng_busy;
      if (srst_active) begin
        srst_cnt <= srst_cnt - 1'b1;
        enable   <= 1'b0;
        compl    <= '0;
      end else if (reg_wr) begin
        case (reg_addr)
          RA_CTRL:  enable <= reg_wdata[0];
          RA_COMPL: compl  <= reg_wdata;
          RA_SRST:  if (reg_wdata[0]) srst_cnt <= CW'(SRST_CYCLES);
          default:  ;
        endcase
      end
      if (td_done) compl <= TD_SENTINEL;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL:  reg_rdata <= {{(WORD_W-1){1'b0}}, enable};
          RA_HEAD:  reg_rdata <= eng_head;
          RA_COMPL: reg_rdata <= compl;
          RA_SRST:  reg_rdata <= {{(WORD_W-1){1'b0}}, srst_active};
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] start_ptr,
  input  logic              td_req,
  output logic              busy,
  output logic [WORD_W-1:0] cur_ptr,
  output logic              td_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_directed,
  output logic [PORT_W-1:0] out_port
);
  walk_state_e       state;
  logic [WORD_W-1:0] link_q;
  logic [WORD_W-1:0] mode_q;
  logic [LEN_W-1:0]  len_q;
  logic              td_pend;
  logic              td_any;
  logic              rt_dir;
  logic [PORT_W-1:0] rt_port;
  logic [1:0]        ofs;

  txq_route i_route (
    .mode     (mem_rdata),
    .directed (rt_dir),
    .port     (rt_port)
  );

  always_comb begin
    td_any    = td_pend || td_req;
    busy      = (state != W_IDLE);
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    ofs       = OFS_LINK;
    case (state)
      W_REQ_LINK: begin mem_req = 1'b1; ofs = OFS_LINK; end
      W_REQ_LEN:  begin mem_req = 1'b1; ofs = OFS_LEN;  end
      W_REQ_MODE: begin mem_req = 1'b1; ofs = OFS_MODE; end
      W_RETIRE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        ofs       = OFS_MODE;
        mem_wdata = mode_q;
        mem_wdata[MB_OWN] = 1'b0;
        if (link_q == '0) mem_wdata[MB_EOQ] = 1'b1;
      end
      W_ABORT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        ofs       = OFS_MODE;
        mem_wdata = mode_q;
        mem_wdata[MB_OWN] = 1'b0;
        mem_wdata[MB_TDC] = 1'b1;
      end
      default: ;
    endcase
    mem_addr = {cur_ptr[AW+1:4], ofs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= W_IDLE;
      cur_ptr      <= '0;
      link_q       <= '0;
      mode_q       <= '0;
      len_q        <= '0;
      td_pend      <= 1'b0;
      td_done      <= 1'b0;
      out_valid    <= 1'b0;
      out_len      <= '0;
      out_directed <= 1'b0;
      out_port     <= '0;
    end else begin
      td_done <= 1'b0;
      if (td_req) td_pend <= 1'b1;
      case (state)
        W_IDLE: begin
          if (td_any) begin
            td_done <= 1'b1;
            td_pend <= 1'b0;
          end else if (start) begin
            cur_ptr <= start_ptr & DESC_MASK;
            state   <= W_REQ_LINK;
          end
        end
        W_REQ_LINK: state <= W_REQ_LEN;
        W_REQ_LEN: begin
          link_q <= mem_rdata;
          state  <= W_REQ_MODE;
        end
        W_REQ_MODE: begin
          len_q <= mem_rdata[LEN_W-1:0];
          state <= W_CHECK;
        end
        W_CHECK: begin
          mode_q <= mem_rdata;
          if (!mem_rdata[MB_OWN]) begin
            cur_ptr <= '0;
            state   <= W_IDLE;
            if (td_any) begin
              td_done <= 1'b1;
              td_pend <= 1'b0;
            end
          end else if (td_any) begin
            state <= W_ABORT;
          end else begin
            out_valid    <= 1'b1;
            out_len      <= len_q;
            out_directed <= rt_dir;
            out_port     <= rt_port;
            state        <= W_EMIT;
          end
        end
        W_EMIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= W_RETIRE;
          end else if (td_any) begin
            out_valid <= 1'b0;
            state     <= W_ABORT;
          end
        end
        W_RETIRE: begin
          if (link_q == '0) begin
            cur_ptr <= '0;
            state   <= W_IDLE;
          end else begin
            cur_ptr <= link_q & DESC_MASK;
            state   <= W_REQ_LINK;
          end
        end
        W_ABORT: begin
          cur_ptr <= '0;
          td_done <= 1'b1;
          td_pend <= 1'b0;
          state   <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_desc_engine.sv
module txq_desc_engine
  import txq_pkg::*;
#(
  parameter int AW          = 10,
  parameter int CHAN_ID     = 0,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              head_err,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_directed,
  output logic [PORT_W-1:0] out_port
);
  logic              start;
  logic [WORD_W-1:0] start_ptr;
  logic              td_req;
  logic              td_done;
  logic              eng_rst;
  logic [WORD_W-1:0] cur_ptr;

  txq_regs #(
    .CHAN_ID     (CHAN_ID),
    .SRST_CYCLES (SRST_CYCLES)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .head_err  (head_err),
    .eng_busy  (busy),
    .eng_head  (cur_ptr),
    .td_done   (td_done),
    .start     (start),
    .start_ptr (start_ptr),
    .td_req    (td_req),
    .eng_rst   (eng_rst)
  );

  txq_walker #(
    .AW (AW)
  ) i_walker (
    .clk          (clk),
    .rst          (eng_rst),
    .start        (start),
    .start_ptr    (start_ptr),
    .td_req       (td_req),
    .busy         (busy),
    .cur_ptr      (cur_ptr),
    .td_done      (td_done),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_len      (out_len),
    .out_directed (out_directed),
    .out_port     (out_port)
  );
endmodule

// File: rtl/txq_desc_engine_chk.sv
module txq_desc_engine_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          head_err,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          out_valid,
  input logic          out_ready,
  input logic [10:0]   out_len,
  input logic          out_directed,
  input logic [2:0]    out_port
);
  assert_len_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_len));

  assert_valid_needs_busy_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  assert_wb_mode_word_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b11));

  assert_wb_owner_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[29]);

  assert_directed_port_R4: assert property (@(posedge clk) disable iff (rst)
    out_directed |-> ((out_port == 3'd1) || (out_port == 3'd2)));

  assert_undirected_port_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_directed) |-> (out_port == 3'd0));

  assert_err_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    head_err |-> $past(busy));

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    head_err |=> !head_err);
endmodule

bind txq_desc_engine txq_desc_engine_chk #(.AW(AW)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .head_err     (head_err),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_len      (out_len),
  .out_directed (out_directed),
  .out_port     (out_port)
);

// File: tb/test_txq_desc_engine.sv
module test_txq_desc_engine;
  localparam int AW      = 8;
  localparam int CHAN    = 2;
  localparam int SRST_N  = 3;
  localparam int NV      = 6;
  localparam logic [31:0] OWN = 32'h2000_0000;
  localparam logic [31:0] EOQ = 32'h1000_0000;
  localparam logic [31:0] TDC = 32'h0800_0000;
  localparam logic [31:0] SENT = 32'hFFFF_FFFC;

  // stimulus table: length and mode word per descriptor of one chain
  localparam logic [10:0] VLEN [NV] = '{11'd64, 11'h5EA, 11'h7FF, 11'd60, 11'd1, 11'd100};
  localparam logic [31:0] VMODE [NV] = '{32'hE000_0040, 32'hE011_05EA, 32'hE012_07FF,
                                         32'hE013_003C, 32'hE001_0001, 32'hE412_0064};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        head_err, busy;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        out_valid, out_directed;
  logic        out_ready = 1'b1;
  logic [10:0] out_len;
  logic [2:0]  out_port;

  logic [31:0] mem [0:(1<<AW)-1];
  logic        tb_wr = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_data = '0;

  int          cap_n = 0;
  logic [10:0] cap_len [32];
  logic        cap_dir [32];
  logic [2:0]  cap_port [32];

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  txq_desc_engine #(.AW(AW), .CHAN_ID(CHAN), .SRST_CYCLES(SRST_N)) i_txq_desc_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .head_err(head_err), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
    .out_directed(out_directed), .out_port(out_port));

  always @(posedge clk) begin
    if (tb_wr) mem[tb_addr] <= tb_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (out_valid && out_ready && cap_n < 32) begin
      cap_len[cap_n]  <= out_len;
      cap_dir[cap_n]  <= out_directed;
      cap_port[cap_n] <= out_port;
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic mem_put(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1'b1; tb_addr = byte_addr[AW+1:2]; tb_data = d;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] link,
                          input logic [31:0] lenw, input logic [31:0] mode);
    mem_put(a,      link);
    mem_put(a + 4,  32'h0001_0000 + a);
    mem_put(a + 8,  lenw);
    mem_put(a + 12, mode);
  endtask

  function automatic logic [31:0] mode_of(input logic [31:0] a);
    return mem[a[AW+1:2] + 3];
  endfunction

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int base_n;
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    check("R12 out_valid", {31'b0, out_valid}, 32'd0);
    check("R12 busy", {31'b0, busy}, 32'd0);
    check("R12 head_err", {31'b0, head_err}, 32'd0);
    reg_read(3'd0, rv); check("R12 ctrl", rv, 32'd0);
    reg_read(3'd1, rv); check("R12 head", rv, 32'd0);
    reg_read(3'd2, rv); check("R12 compl", rv, 32'd0);
    reg_read(3'd4, rv); check("R12 srst", rv, 32'd0);

    // R2 disabled: head write starts nothing
    put_desc(32'h300, 32'h0, 32'd9, 32'hE000_0009);
    reg_write(3'd1, 32'h300);
    repeat (5) @(negedge clk);
    check("R2 disabled busy", {31'b0, busy}, 32'd0);
    reg_read(3'd1, rv); check("R2 disabled head", rv, 32'd0);
    check("R2 disabled no record", cap_n, 0);
    reg_write(3'd0, 32'd1);
    reg_write(3'd1, 32'h0);
    repeat (3) @(negedge clk);
    check("R2 zero head busy", {31'b0, busy}, 32'd0);

    // table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < NV; i++)
      put_desc(32'h40 + 16 * i, (i == NV - 1) ? 32'h0 : 32'h40 + 16 * (i + 1),
               32'hABC0_0000 | 32'(VLEN[i]), VMODE[i]);
    base_n = cap_n;
    reg_write(3'd1, 32'h40);
    wait_idle();
    check("R3 record count", cap_n - base_n, NV);
    for (int i = 0; i < NV; i++) begin
      logic [2:0] pf;
      logic dir;
      pf  = VMODE[i][18:16];
      dir = VMODE[i][20] && (pf == 3'd1 || pf == 3'd2);
      check("R3 length", {21'b0, cap_len[base_n + i]}, {21'b0, VLEN[i]});
      check("R4 routing", {28'b0, cap_dir[base_n + i], cap_port[base_n + i]},
            {28'b0, dir, dir ? pf : 3'd0});
      check("R5 R6 writeback", mode_of(32'h40 + 16 * i),
            (VMODE[i] & ~OWN) | ((i == NV - 1) ? EOQ : 32'h0));
    end
    reg_read(3'd1, rv); check("R6 head after eoq", rv, 32'd0);

    // R6 restart from new head (R1: low address bits ignored)
    base_n = cap_n;
    reg_write(3'd1, 32'h305);
    wait_idle();
    check("R6 restart record", cap_n - base_n, 1);
    check("R6 restart length", {21'b0, cap_len[base_n]}, 32'd9);
    check("R1 aligned writeback", mode_of(32'h300), 32'hD000_0009);

    // R7 owner clear stops the walk
    put_desc(32'h340, 32'h350, 32'd5, 32'hC000_0005);
    put_desc(32'h350, 32'h0, 32'd6, 32'hE000_0006);
    base_n = cap_n;
    reg_write(3'd1, 32'h340);
    wait_idle();
    check("R7 no record", cap_n - base_n, 0);
    check("R7 mode untouched", mode_of(32'h340), 32'hC000_0005);
    check("R7 successor untouched", mode_of(32'h350), 32'hE000_0006);
    reg_read(3'd1, rv); check("R7 head", rv, 32'd0);

    // R3 hold, R8 busy head write, R10 teardown
    put_desc(32'h200, 32'h210, 32'd77, 32'hE000_004D);
    put_desc(32'h210, 32'h0, 32'd88, 32'hE000_0058);
    base_n = cap_n;
    out_ready = 1'b0;
    reg_write(3'd1, 32'h200);
    repeat (10) @(negedge clk);
    check("R3 held valid", {31'b0, out_valid}, 32'd1);
    check("R3 held length", {21'b0, out_len}, 32'd77);
    reg_write(3'd1, 32'h210);
    check("R8 err pulse", {31'b0, head_err}, 32'd1);
    @(negedge clk);
    check("R8 err one cycle", {31'b0, head_err}, 32'd0);
    reg_read(3'd1, rv); check("R8 head kept", rv, 32'h200);
    reg_write(3'd3, 32'd0);
    repeat (4) @(negedge clk);
    check("R10 wrong id ignored", {30'b0, busy, out_valid}, 32'd3);
    reg_write(3'd3, CHAN);
    wait_idle();
    check("R10 record dropped", cap_n - base_n, 0);
    check("R10 marked desc", mode_of(32'h200), (32'hE000_004D & ~OWN) | TDC);
    check("R10 later desc", mode_of(32'h210), 32'hE000_0058);
    reg_read(3'd2, rv); check("R10 sentinel", rv, SENT);
    out_ready = 1'b1;

    // R9 completion register
    reg_write(3'd2, SENT);
    reg_read(3'd2, rv); check("R9 ack value", rv, SENT);
    reg_write(3'd2, 32'h140);
    reg_read(3'd2, rv); check("R9 readback", rv, 32'h140);

    // R10 teardown while idle
    reg_write(3'd3, CHAN);
    repeat (3) @(negedge clk);
    reg_read(3'd2, rv); check("R10 idle sentinel", rv, SENT);

    // R11 soft reset
    reg_write(3'd2, 32'h1234);
    reg_write(3'd4, 32'd1);
    reg_read(3'd4, rv); check("R11 srst busy", rv, 32'd1);
    repeat (6) @(negedge clk);
    reg_read(3'd4, rv); check("R11 srst done", rv, 32'd0);
    reg_read(3'd0, rv); check("R11 enable cleared", rv, 32'd0);
    reg_read(3'd2, rv); check("R11 compl cleared", rv, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule